// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Window

This block controls a one-time-programmable fuse array of `NUM_BANKS` banks of `WORDS_PER_BANK` 32-bit words, with 16 × 8 as the default. The fuse array is modelled as internal flops. Software sees the block through a simple 32-bit register bus. A control register holds a word address, status flags and a 16-bit unlock key. A separate alias of the control register lets software set individual bits. A timing register holds three strobe counts, and a data register starts a program operation when it is written.

Every fuse word is also mirrored in a read-only shadow register. Software reads the shadows through a window of 16-byte slots. That window leaves a gap of two bank-sized slot groups after bank 5. A program operation only changes the fuse array. The shadows are refreshed by a reload sequence, which software requests through the set alias. The controller also starts a reload on its own when reset is released. A program operation can only turn fuse bits from 0 to 1.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Reset clears the address, key, error and timing fields, and sets the reload bit (bit 10) of the control register. The controller then starts a reload by itself. Once the reload finishes, the control register reads 0 and the shadows of a blank array read 0.
- R2: A read request returns its data with `bus_rvalid` high in the cycle after the request. The register offsets are: control at 0x00, set alias at 0x04, timing at 0x10, data at 0x20. The timing register keeps only the read strobe count in bits [21:16], the relax count in [15:12] and the program strobe count in [11:0]; all other bits read 0. The data register reads back the last value written to it.
- R3: Writing the data register starts a program operation only in one case: the control register's bits [31:16] hold 0x3E77 while bits [6:0] hold the logical word index (bank*8+word), and no operation is running or pending.
- R4: A program operation holds BUSY (bit 8) high for (prog+1)+2*(relax+1) cycles, counted from the cycle after the data write. When BUSY clears, the key field reads 0.
- R5: A program operation ORs the data into the addressed fuse word, so a bit that is already 1 stays 1.
- R6: A data write is refused, with ERROR (bit 9) set and no fuse changed, in either of two cases: the key is wrong, or BUSY or a pending reload is set.
- R7: Once set, ERROR stays set. A write to offset 0x00 with bit 9 equal to 1 leaves it set. Only a write to offset 0x00 with bit 9 equal to 0 clears it.
- R8: A write to offset 0x04 ORs its address, key, error and reload bits into the control register and leaves every other bit unchanged. A write to offset 0x00 replaces the address and key fields.
- R9: Setting the reload bit starts a reload in the next cycle. RELOAD and BUSY then stay high for (read+1)+NUM_WORDS cycles. After that, every shadow equals its fuse word. The shadows do not change between reloads.
- R10: Logical word n is read at byte offset 0x400 + p*0x10, where p = n for banks 0 to 5 and p = n+16 for banks 6 and above. Bank 5 therefore ends at 0x6F0 and bank 6 begins at 0x800.
- R11: A read returns 0 in each of these cases: a slot in the gap (0x700 to 0x7F0), a slot beyond the last word, or an address whose low four bits are not zero. Writes to the shadow window change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after a read request |

## Verification
The bench builds the block with its default geometry: 16 banks of 8 words, with two gap banks after bank 5. This geometry makes both the slots on either side of the gap (0x6F0 and 0x800) and the last word at 0xCF0 reachable addresses. The bench programs a timing register with small counts (program strobe 9, relax 1, read strobe 2). With these counts, the exact last busy cycle of a program operation (14 cycles) and of a reload (131 cycles) can be sampled one cycle apart, on both sides of the edge.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int REG_W        = 32;
    localparam int CTL_BUSY     = 8;
    localparam int CTL_ERR      = 9;
    localparam int CTL_RELOAD   = 10;
    localparam int CTL_KEY_LSB  = 16;
    localparam int KEY_W        = 16;
    localparam logic [KEY_W-1:0] PROG_KEY = 16'h3E77;

    localparam int TM_PROG_LSB  = 0;
    localparam int TM_PROG_W    = 12;
    localparam int TM_RELAX_LSB = 12;
    localparam int TM_RELAX_W   = 4;
    localparam int TM_READ_LSB  = 16;
    localparam int TM_READ_W    = 6;

    localparam int OFF_CTL      = 'h000;
    localparam int OFF_CTL_SET  = 'h004;
    localparam int OFF_TIMING   = 'h010;
    localparam int OFF_DATA     = 'h020;
    localparam int OFF_SHADOW   = 'h400;
    localparam int SLOT_LOG     = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PROG,
        SQ_STROBE,
        SQ_COPY
    } seq_state_e;
endpackage

// File: rtl/otp_regs.sv
module otp_regs
    import otp_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int ADDR_W    = 7,
    parameter int BUS_AW    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BUS_AW-1:0]     wr_addr,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  seq_busy,
    input  logic                  prog_done,
    input  logic                  reload_done,
    output logic [ADDR_W-1:0]     word_addr,
    output logic [KEY_W-1:0]      key,
    output logic                  err,
    output logic                  reload,
    output logic [TM_PROG_W-1:0]  t_prog,
    output logic [TM_RELAX_W-1:0] t_relax,
    output logic [TM_READ_W-1:0]  t_read,
    output logic [REG_W-1:0]      data,
    output logic                  start
);
    typedef struct packed {
        logic [ADDR_W-1:0]     addr;
        logic [KEY_W-1:0]      key;
        logic                  err;
        logic                  reload;
        logic [TM_READ_W-1:0]  trd;
        logic [TM_RELAX_W-1:0] trl;
        logic [TM_PROG_W-1:0]  tpg;
        logic [REG_W-1:0]      data;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  bad_req;

    always_comb begin
        regs_d  = regs_q;
        start   = 1'b0;
        bad_req = seq_busy || regs_q.reload || (regs_q.key != PROG_KEY)
                  || ({1'b0, regs_q.addr} >= (ADDR_W+1)'(NUM_WORDS));
        if (prog_done)   regs_d.key    = '0;
        if (reload_done) regs_d.reload = 1'b0;
        if (wr_en) begin
            if (wr_addr == BUS_AW'(OFF_CTL)) begin
                regs_d.addr = wdata[ADDR_W-1:0];
                regs_d.key  = wdata[CTL_KEY_LSB +: KEY_W];
                if (!wdata[CTL_ERR]) regs_d.err = 1'b0;
            end else if (wr_addr == BUS_AW'(OFF_CTL_SET)) begin
                regs_d.addr   = regs_q.addr | wdata[ADDR_W-1:0];
                regs_d.key    = regs_d.key | wdata[CTL_KEY_LSB +: KEY_W];
                regs_d.err    = regs_q.err | wdata[CTL_ERR];
                regs_d.reload = regs_d.reload | wdata[CTL_RELOAD];
            end else if (wr_addr == BUS_AW'(OFF_TIMING)) begin
                regs_d.tpg = wdata[TM_PROG_LSB +: TM_PROG_W];
                regs_d.trl = wdata[TM_RELAX_LSB +: TM_RELAX_W];
                regs_d.trd = wdata[TM_READ_LSB +: TM_READ_W];
            end else if (wr_addr == BUS_AW'(OFF_DATA)) begin
                regs_d.data = wdata;
                if (bad_req) regs_d.err = 1'b1;
                else         start      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q        <= '0;
            regs_q.reload <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign word_addr = regs_q.addr;
    assign key       = regs_q.key;
    assign err       = regs_q.err;
    assign reload    = regs_q.reload;
    assign t_prog    = regs_q.tpg;
    assign t_relax   = regs_q.trl;
    assign t_read    = regs_q.trd;
    assign data      = regs_q.data;

    // R7: error is sticky until a plain control write with bit 9 low
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(regs_q.err) && !$past(wr_en && (wr_addr == BUS_AW'(OFF_CTL)) && !wdata[CTL_ERR]))
        |-> regs_q.err);
endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int ADDR_W    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [REG_W-1:0]      start_data,
    input  logic                  reload_req,
    input  logic [TM_PROG_W-1:0]  t_prog,
    input  logic [TM_RELAX_W-1:0] t_relax,
    input  logic [TM_READ_W-1:0]  t_read,
    output logic                  busy,
    output logic                  commit_en,
    output logic [ADDR_W-1:0]     commit_addr,
    output logic [REG_W-1:0]      commit_data,
    output logic                  copy_en,
    output logic [ADDR_W-1:0]     copy_idx,
    output logic                  reload_done
);
    localparam int CNT_W = TM_PROG_W + 2;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] paddr;
        logic [REG_W-1:0]  pdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        commit_en   = 1'b0;
        copy_en     = 1'b0;
        reload_done = 1'b0;
        case (seq_q.state)
            SQ_IDLE: begin
                if (start) begin
                    seq_d.state = SQ_PROG;
                    seq_d.cnt   = CNT_W'(t_prog) + CNT_W'({t_relax, 1'b0}) + CNT_W'(2);
                    seq_d.paddr = start_addr;
                    seq_d.pdata = start_data;
                end else if (reload_req) begin
                    seq_d.state = SQ_STROBE;
                    seq_d.cnt   = CNT_W'(t_read);
                end
            end
            SQ_PROG: begin
                if (seq_q.cnt == '0) begin
                    commit_en   = 1'b1;
                    seq_d.state = SQ_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SQ_COPY;
                    seq_d.idx   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_COPY: begin
                copy_en = 1'b1;
                if (seq_q.idx == LAST_IDX) begin
                    reload_done = 1'b1;
                    seq_d.state = SQ_IDLE;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy        = (seq_q.state != SQ_IDLE);
    assign commit_addr = seq_q.paddr;
    assign commit_data = seq_q.pdata;
    assign copy_idx    = seq_q.idx;

    // R9: the shadow copy walks every word without a pause
    p_copy_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_en && (copy_idx != LAST_IDX)) |=> (copy_en && (copy_idx == $past(copy_idx) + 1'b1)));
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
    import otp_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int ADDR_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [REG_W-1:0]  commit_data,
    input  logic              copy_en,
    input  logic [ADDR_W-1:0] copy_idx,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [REG_W-1:0]  rd_word
);
    logic [REG_W-1:0] fuse_d [NUM_WORDS];
    logic [REG_W-1:0] fuse_q [NUM_WORDS];
    logic [REG_W-1:0] shad_d [NUM_WORDS];
    logic [REG_W-1:0] shad_q [NUM_WORDS];

    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            fuse_d[w] = fuse_q[w];
            shad_d[w] = shad_q[w];
            if (commit_en && (commit_addr == ADDR_W'(w)))
                fuse_d[w] = fuse_q[w] | commit_data;
            if (copy_en && (copy_idx == ADDR_W'(w)))
                shad_d[w] = fuse_q[w];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                fuse_q[w] <= '0;
                shad_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                fuse_q[w] <= fuse_d[w];
                shad_q[w] <= shad_d[w];
            end
        end
    end

    assign rd_word = shad_q[rd_idx];

    // R5: after a program, every data bit is set in the target word
    p_fuse_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> ((fuse_q[$past(commit_addr)] & $past(commit_data)) == $past(commit_data)));
endmodule

// File: rtl/otp_shadow_map.sv
module otp_shadow_map
    import otp_pkg::*;
#(
    parameter int NUM_WORDS      = 128,
    parameter int ADDR_W         = 7,
    parameter int BUS_AW         = 12,
    parameter int WORDS_PER_BANK = 8,
    parameter int GAP_AFTER_BANK = 5,
    parameter int GAP_BANKS      = 2
) (
    input  logic [BUS_AW-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] idx
);
    localparam int SLOT_W  = BUS_AW - SLOT_LOG;
    localparam int GAP_LO  = (GAP_AFTER_BANK + 1) * WORDS_PER_BANK;
    localparam int GAP_LEN = GAP_BANKS * WORDS_PER_BANK;

    logic              in_win;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] logical;
    logic              in_gap;

    assign in_win = (addr >= BUS_AW'(OFF_SHADOW)) && (addr[SLOT_LOG-1:0] == '0);
    assign slot   = addr[BUS_AW-1:SLOT_LOG] - SLOT_W'(OFF_SHADOW >> SLOT_LOG);

    generate
        if (GAP_BANKS == 0) begin : g_flat
            assign in_gap  = 1'b0;
            assign logical = slot;
        end else begin : g_hole
            assign in_gap  = (slot >= SLOT_W'(GAP_LO)) && (slot < SLOT_W'(GAP_LO + GAP_LEN));
            assign logical = (slot < SLOT_W'(GAP_LO)) ? slot : (slot - SLOT_W'(GAP_LEN));
        end
    endgenerate

    assign hit = in_win && !in_gap && (logical < SLOT_W'(NUM_WORDS));
    assign idx = logical[ADDR_W-1:0];
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int NUM_BANKS      = 16,
    parameter int WORDS_PER_BANK = 8,
    parameter int GAP_AFTER_BANK = 5,
    parameter int GAP_BANKS      = 2,
    parameter int BUS_AW         = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid
);
    localparam int NUM_WORDS = NUM_BANKS * WORDS_PER_BANK;
    localparam int ADDR_W    = $clog2(NUM_WORDS);

    logic                  wr_en;
    logic [ADDR_W-1:0]     word_addr;
    logic [KEY_W-1:0]      key;
    logic                  err, reload, start, busy;
    logic [TM_PROG_W-1:0]  t_prog;
    logic [TM_RELAX_W-1:0] t_relax;
    logic [TM_READ_W-1:0]  t_read;
    logic [REG_W-1:0]      data;
    logic                  commit_en, copy_en, reload_done;
    logic [ADDR_W-1:0]     commit_addr, copy_idx, shadow_idx;
    logic [REG_W-1:0]      commit_data, shadow_word;
    logic                  shadow_hit;

    assign wr_en = bus_req && bus_we;

    otp_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr), .wdata(bus_wdata),
        .seq_busy(busy), .prog_done(commit_en), .reload_done(reload_done),
        .word_addr(word_addr), .key(key), .err(err), .reload(reload),
        .t_prog(t_prog), .t_relax(t_relax), .t_read(t_read), .data(data), .start(start)
    );

    otp_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(word_addr), .start_data(bus_wdata),
        .reload_req(reload), .t_prog(t_prog), .t_relax(t_relax), .t_read(t_read),
        .busy(busy), .commit_en(commit_en), .commit_addr(commit_addr), .commit_data(commit_data),
        .copy_en(copy_en), .copy_idx(copy_idx), .reload_done(reload_done)
    );

    otp_fuse_store #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_en(commit_en), .commit_addr(commit_addr),
        .commit_data(commit_data), .copy_en(copy_en), .copy_idx(copy_idx),
        .rd_idx(shadow_idx), .rd_word(shadow_word)
    );

    otp_shadow_map #(
        .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .BUS_AW(BUS_AW),
        .WORDS_PER_BANK(WORDS_PER_BANK), .GAP_AFTER_BANK(GAP_AFTER_BANK), .GAP_BANKS(GAP_BANKS)
    ) u_map (
        .addr(bus_addr), .hit(shadow_hit), .idx(shadow_idx)
    );

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
    } rsp_t;

    rsp_t             rsp_d, rsp_q;
    logic [REG_W-1:0] ctl_word, tim_word;

    always_comb begin
        ctl_word = '0;
        ctl_word[ADDR_W-1:0]             = word_addr;
        ctl_word[CTL_BUSY]               = busy;
        ctl_word[CTL_ERR]                = err;
        ctl_word[CTL_RELOAD]             = reload;
        ctl_word[CTL_KEY_LSB +: KEY_W]   = key;
        tim_word = '0;
        tim_word[TM_PROG_LSB +: TM_PROG_W]   = t_prog;
        tim_word[TM_RELAX_LSB +: TM_RELAX_W] = t_relax;
        tim_word[TM_READ_LSB +: TM_READ_W]   = t_read;

        rsp_d.valid = bus_req && !bus_we;
        if ((bus_addr == BUS_AW'(OFF_CTL)) || (bus_addr == BUS_AW'(OFF_CTL_SET)))
            rsp_d.data = ctl_word;
        else if (bus_addr == BUS_AW'(OFF_TIMING))
            rsp_d.data = tim_word;
        else if (bus_addr == BUS_AW'(OFF_DATA))
            rsp_d.data = data;
        else if (shadow_hit)
            rsp_d.data = shadow_word;
        else
            rsp_d.data = '0;
        if (!rsp_d.valid) rsp_d.data = rsp_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rdata  = rsp_q.data;
    assign bus_rvalid = rsp_q.valid;

    logic ctl_write;
    assign ctl_write = wr_en && ((bus_addr == BUS_AW'(OFF_CTL)) || (bus_addr == BUS_AW'(OFF_CTL_SET)));

    // R2: read response one cycle after the request
    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R4: an accepted program makes the sequencer busy next cycle
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R4: key field is empty after a program completes
    p_key_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !ctl_write) |=> (key == '0));

    // R6: no program is accepted while the sequencer runs or a reload waits
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!busy && !reload));

    // R9: reload bit drops when the copy finishes
    p_reload_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_done && !ctl_write) |=> !reload);
endmodule

// File: tb/sim_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module sim_otp_fuse_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] mask_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    otp_fuse_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    localparam logic [11:0] A_CTL = 12'h000, A_SET = 12'h004, A_TIM = 12'h010, A_DAT = 12'h020;

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
        @(negedge clk);
        exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_reload();
        bus_wr(A_SET, 32'h0000_0400);
        idle(140);
    endtask

    // monitor: compare each read response against the scoreboard
    always @(negedge clk) begin
        if (bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e, m;
                string t;
                e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
                if ((bus_rdata & m) != e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata & m, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reload bit set after reset, auto reload runs
        bus_rd(A_CTL, 32'h0000_0400, 32'h0000_0400, "R1 reload after reset");
        idle(200);
        bus_rd(A_CTL, 32'h0, 32'hFFFF_FFFF, "R1 ctrl idle after auto reload");
        bus_rd(A_TIM, 32'h0, 32'hFFFF_FFFF, "R1 timing cleared");
        bus_rd(12'h400, 32'h0, 32'hFFFF_FFFF, "R1 blank shadow");

        // R2: timing field masking, data readback
        bus_wr(A_TIM, 32'hFFFF_FFFF);
        bus_rd(A_TIM, 32'h003F_FFFF, 32'hFFFF_FFFF, "R2 timing mask");
        bus_wr(A_TIM, 32'h0002_1009);
        bus_rd(A_TIM, 32'h0002_1009, 32'hFFFF_FFFF, "R2 timing value");

        // R3/R4: program word 5, busy window of 14 cycles
        bus_wr(A_CTL, 32'h3E77_0005);
        bus_wr(A_DAT, 32'h0000_00A5);
        idle(13);
        bus_rd(A_CTL, 32'h3E77_0105, 32'hFFFF_FFFF, "R4 busy on last cycle");
        bus_rd(A_CTL, 32'h0000_0005, 32'hFFFF_FFFF, "R4 busy clear and key cleared");
        bus_rd(A_DAT, 32'h0000_00A5, 32'hFFFF_FFFF, "R2 data readback");
        // R9: shadow unchanged before reload
        bus_rd(12'h450, 32'h0, 32'hFFFF_FFFF, "R9 shadow stale before reload");

        // R9: reload window of 3+128 cycles
        bus_wr(A_SET, 32'h0000_0400);
        idle(131);
        bus_rd(A_CTL, 32'h0000_0505, 32'hFFFF_FFFF, "R9 reload busy last cycle");
        bus_rd(A_CTL, 32'h0000_0005, 32'hFFFF_FFFF, "R9 reload finished");
        bus_rd(12'h450, 32'h0000_00A5, 32'hFFFF_FFFF, "R9 R10 shadow word 5");

        // R5: OR into existing fuse word
        bus_wr(A_CTL, 32'h3E77_0005);
        bus_wr(A_DAT, 32'h0F00_000A);
        idle(20);
        do_reload();
        bus_rd(12'h450, 32'h0F00_00AF, 32'hFFFF_FFFF, "R5 fuse bits OR");

        // R10: map across the gap and at the last word
        bus_wr(A_CTL, 32'h3E77_0030); bus_wr(A_DAT, 32'h1234_5678); idle(20);
        bus_wr(A_CTL, 32'h3E77_007F); bus_wr(A_DAT, 32'hCAFE_F00D); idle(20);
        bus_wr(A_CTL, 32'h3E77_002F); bus_wr(A_DAT, 32'h4747_4747); idle(20);
        do_reload();
        bus_rd(12'h800, 32'h1234_5678, 32'hFFFF_FFFF, "R10 bank 6 word 0");
        bus_rd(12'hCF0, 32'hCAFE_F00D, 32'hFFFF_FFFF, "R10 last word");
        bus_rd(12'h6F0, 32'h4747_4747, 32'hFFFF_FFFF, "R10 bank 5 word 7");
        bus_rd(12'h480, 32'h0, 32'hFFFF_FFFF, "R10 bank 1 word 0 untouched");
        // R11: gap, beyond end, unaligned
        bus_rd(12'h700, 32'h0, 32'hFFFF_FFFF, "R11 gap start");
        bus_rd(12'h7F0, 32'h0, 32'hFFFF_FFFF, "R11 gap end");
        bus_rd(12'hD00, 32'h0, 32'hFFFF_FFFF, "R11 beyond last word");
        bus_rd(12'h804, 32'h0, 32'hFFFF_FFFF, "R11 unaligned slot");
        bus_wr(12'h800, 32'hFFFF_FFFF);
        bus_rd(12'h800, 32'h1234_5678, 32'hFFFF_FFFF, "R11 shadow write ignored");

        // R6: wrong key
        bus_wr(A_CTL, 32'h1234_0003);
        bus_wr(A_DAT, 32'h0000_0001);
        bus_rd(A_CTL, 32'h1234_0203, 32'hFFFF_FFFF, "R6 wrong key error");
        // R7: sticky error
        bus_wr(A_CTL, 32'h0000_0203);
        bus_rd(A_CTL, 32'h0000_0203, 32'hFFFF_FFFF, "R7 error kept with bit9=1");
        bus_wr(A_CTL, 32'h0000_0003);
        bus_rd(A_CTL, 32'h0000_0003, 32'hFFFF_FFFF, "R7 error cleared with bit9=0");
        do_reload();
        bus_rd(12'h430, 32'h0, 32'hFFFF_FFFF, "R6 wrong key no program");

        // R3: key is consumed, a second data write is refused
        bus_wr(A_CTL, 32'h3E77_0002);
        bus_wr(A_DAT, 32'h0000_0001);
        idle(20);
        bus_wr(A_DAT, 32'h0000_0002);
        bus_rd(A_CTL, 32'h0000_0202, 32'hFFFF_FFFF, "R3 refused without key");
        bus_wr(A_CTL, 32'h0000_0000);
        do_reload();
        bus_rd(12'h420, 32'h0000_0001, 32'hFFFF_FFFF, "R3 only keyed write programmed");

        // R6: data write while busy
        bus_wr(A_CTL, 32'h3E77_0004);
        bus_wr(A_DAT, 32'h0000_0010);
        bus_wr(A_DAT, 32'h0000_0020);
        idle(20);
        bus_rd(A_CTL, 32'h0000_0204, 32'hFFFF_FFFF, "R6 busy write error");
        bus_wr(A_CTL, 32'h0000_0000);
        do_reload();
        bus_rd(12'h440, 32'h0000_0010, 32'hFFFF_FFFF, "R6 busy write not programmed");

        // R8: set alias
        bus_wr(A_CTL, 32'h0000_0001);
        bus_wr(A_SET, 32'h0000_0002);
        bus_rd(A_CTL, 32'h0000_0003, 32'hFFFF_FFFF, "R8 alias ORs address");
        bus_wr(A_SET, 32'h3E77_0000);
        bus_rd(A_SET, 32'h3E77_0003, 32'hFFFF_FFFF, "R8 alias ORs key");
        bus_wr(A_CTL, 32'h0000_0000);
        bus_rd(A_CTL, 32'h0, 32'hFFFF_FFFF, "R8 plain write replaces fields");

        idle(5);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule